// File: doc/BRIEF.md
# Fine-Grained Multithreaded Thread Selector

This block sits in the thread-select stage of a single-issue, in-order core whose six stages are fetch, thread-select, decode, execute, memory and writeback. The core interleaves four hardware threads. In every cycle the selector names one thread to issue from and skips any thread that cannot make progress. A thread drops out when it is waiting on a cache miss, or when it sits in the fixed three-cycle shadow that follows a load or a branch. Other threads fill those cycles. The stage leaves a bubble only when no thread is available.

Each thread is tracked by a small state machine. Its states are `THR_READY`, `THR_SHADOW` (a delay counter is running) and `THR_MISS` (waiting for a miss to complete). The transitions are named as follows. `miss_begin` moves READY or SHADOW to MISS on a miss-start pulse. `shadow_begin` moves READY to SHADOW on a load or branch issue. `shadow_reload` keeps SHADOW and restarts its counter on a new issue. `shadow_end` moves SHADOW to READY when the counter runs out. `miss_end` moves MISS to READY on a miss-complete pulse. A round-robin picker scans the ready threads. It starts at the thread just after the one that issued most recently.

Top module: `fgmt_thread_select`

## Requirements
- R1: While reset is held and in the first cycle after it is released, every thread is ready, `sel_valid` is 1 and `sel_tid` is 0. With no stall events, the selection then walks 1, 2, 3, 0.
- R2: When two or more threads are ready, the selected thread differs from the one selected in the previous valid cycle.
- R3: The selection is always a ready thread: the first ready thread in ascending order (wrapping from 3 to 0) after the most recently issued thread. Unavailable threads are skipped.
- R4: A `miss_start[i]` pulse makes thread i unselectable from the next cycle on. The thread stays out until the cycle after a `miss_done[i]` pulse.
- R5: A `delay_issue[i]` pulse on a ready thread makes thread i unselectable for exactly the three following cycles. It is selectable again in the fourth cycle.
- R6: A `delay_issue[i]` pulse while thread i is already in its shadow restarts the three-cycle count from that pulse.
- R7: A `miss_start[i]` pulse during a shadow moves the thread into the miss stall. It then stays out until `miss_done[i]`, even after the shadow would have ended.
- R8: A `miss_done[i]` pulse on a thread that is not in a miss stall has no effect.
- R9: A `delay_issue[i]` pulse on a thread in a miss stall is ignored. The thread becomes ready the cycle after `miss_done[i]`.
- R10: When no thread is ready, `sel_valid` is 0 and `sel_tid` is 0. The most recently issued thread is left unchanged.
- R11: When exactly one thread is ready, it is selected in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_start | input | 4 | Per-thread pulse: a cache miss has begun |
| miss_done | input | 4 | Per-thread pulse: the miss has been serviced |
| delay_issue | input | 4 | Per-thread pulse: a load or branch was issued |
| sel_tid | output | 2 | Thread selected this cycle |
| sel_valid | output | 1 | A thread issues this cycle (0 means a bubble) |

## Verification
The hardest cases to reach are the overlaps between stall kinds on one thread. Examples are a miss that begins inside a load shadow, an issue pulse that lands while a miss is outstanding, and a reload in mid-shadow. In each of these the thread's availability differs by only a cycle or two from the non-overlapping case. The stimulus places each pulse in the exact cycle the target thread is selected or shadowed. It then releases the miss or lets the shadow run out at a point where the two possible behaviours give different thread orders at the ports. The all-stalled bubble is reached by parking three threads in misses and putting the fourth into a shadow.

// File: rtl/fgmt_pkg.sv
package fgmt_pkg;

    typedef enum logic [1:0] {
        THR_READY  = 2'd0,
        THR_SHADOW = 2'd1,
        THR_MISS   = 2'd2
    } thr_state_e;

endpackage

// File: rtl/ts_thread_fsm.sv
module ts_thread_fsm
    import fgmt_pkg::*;
#(
    parameter int SHADOW_CYC = 3,
    localparam int CNT_W = $clog2(SHADOW_CYC + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic miss_start,
    input  logic miss_done,
    input  logic delay_issue,
    output logic ready
);

    localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SHADOW_CYC);
    localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

    thr_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= THR_READY;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            THR_READY: begin
                if (miss_start) begin              // miss_begin
                    state_d = THR_MISS;
                    cnt_d   = '0;
                end else if (delay_issue) begin    // shadow_begin
                    state_d = THR_SHADOW;
                    cnt_d   = LOAD_VAL;
                end
            end
            THR_SHADOW: begin
                if (miss_start) begin              // miss_begin
                    state_d = THR_MISS;
                    cnt_d   = '0;
                end else if (delay_issue) begin    // shadow_reload
                    cnt_d   = LOAD_VAL;
                end else if (cnt_q <= ONE) begin   // shadow_end
                    state_d = THR_READY;
                    cnt_d   = '0;
                end else begin
                    cnt_d   = cnt_q - ONE;
                end
            end
            THR_MISS: begin
                if (miss_done) begin               // miss_end
                    state_d = THR_READY;
                end
            end
            default: begin
                state_d = THR_READY;
                cnt_d   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        ready = (state_q == THR_READY);
    end

endmodule

// File: rtl/ts_rr_pick.sv
module ts_rr_pick #(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic [NUM_THREADS-1:0] elig,
    input  logic [TID_W-1:0]       last_tid,
    output logic                   pick_valid,
    output logic [TID_W-1:0]       pick_tid
);

    function automatic int wrap_idx(input int base, input int off);
        int s;
        s = base + off;
        if (s >= NUM_THREADS) s = s - NUM_THREADS;
        return s;
    endfunction

    always_comb begin
        pick_valid = 1'b0;
        pick_tid   = '0;
        for (int off = 1; off <= NUM_THREADS; off++) begin
            if (!pick_valid && elig[wrap_idx(int'(last_tid), off)]) begin
                pick_valid = 1'b1;
                pick_tid   = TID_W'(wrap_idx(int'(last_tid), off));
            end
        end
    end

endmodule

// File: rtl/fgmt_thread_select.sv
module fgmt_thread_select #(
    parameter int NUM_THREADS = 4,
    parameter int SHADOW_CYC  = 3,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NUM_THREADS-1:0] miss_start,
    input  logic [NUM_THREADS-1:0] miss_done,
    input  logic [NUM_THREADS-1:0] delay_issue,
    output logic [TID_W-1:0]       sel_tid,
    output logic                   sel_valid
);

    logic [NUM_THREADS-1:0] thr_ready;
    logic [TID_W-1:0]       last_q;
    logic                   pick_v;
    logic [TID_W-1:0]       pick_t;

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_thr
        ts_thread_fsm #(.SHADOW_CYC(SHADOW_CYC)) fsm_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .miss_start (miss_start[g]),
            .miss_done  (miss_done[g]),
            .delay_issue(delay_issue[g]),
            .ready      (thr_ready[g])
        );
    end

    ts_rr_pick #(.NUM_THREADS(NUM_THREADS)) pick_i (
        .elig      (thr_ready),
        .last_tid  (last_q),
        .pick_valid(pick_v),
        .pick_tid  (pick_t)
    );

    // Last-issued pointer: reset so that thread 0 comes first
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            last_q <= TID_W'(NUM_THREADS - 1);
        end else if (pick_v) begin
            last_q <= pick_t;
        end
    end

    always_comb begin
        sel_valid = pick_v;
        sel_tid   = pick_v ? pick_t : '0;
    end

endmodule

// File: rtl/fgmt_thread_select_chk.sv
module fgmt_thread_select_chk #(
    parameter int NUM_THREADS = 4,
    localparam int TID_W = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_THREADS-1:0] miss_start,
    input logic [NUM_THREADS-1:0] miss_done,
    input logic [NUM_THREADS-1:0] delay_issue,
    input logic [TID_W-1:0]       sel_tid,
    input logic                   sel_valid,
    input logic [NUM_THREADS-1:0] elig
);

    logic armed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R3: the selection is a ready thread
    assert_sel_is_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        sel_valid |-> elig[sel_tid]);

    // R10: a bubble only when no thread is ready
    assert_bubble_only_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_valid |-> (elig == '0) && (sel_tid == '0));

    // R11: any ready thread means an issue
    assert_issue_when_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (elig != '0) |-> sel_valid);

    // R2: switch thread each cycle when there is a choice
    assert_switch_each_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && sel_valid && $past(sel_valid) && ($countones(elig) >= 2))
        |-> (sel_tid != $past(sel_tid)));

    for (genvar g = 0; g < NUM_THREADS; g++) begin : g_chk
        // R4: a miss removes the thread the next cycle
        assert_miss_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
            miss_start[g] |=> !(sel_valid && (sel_tid == TID_W'(g))));

        // R5: a load or branch removes the thread the next cycle
        assert_shadow_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (delay_issue[g] && !miss_done[g]) |=> !(sel_valid && (sel_tid == TID_W'(g))));
    end

endmodule

bind fgmt_thread_select fgmt_thread_select_chk #(.NUM_THREADS(NUM_THREADS)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .miss_start (miss_start),
    .miss_done  (miss_done),
    .delay_issue(delay_issue),
    .sel_tid    (sel_tid),
    .sel_valid  (sel_valid),
    .elig       (thr_ready)
);

// File: tb/fgmt_thread_select_tb_top.sv
module fgmt_thread_select_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] miss_start = '0;
    logic [3:0] miss_done = '0;
    logic [3:0] delay_issue = '0;
    logic [1:0] sel_tid;
    logic       sel_valid;

    typedef struct {
        logic       v;
        logic [1:0] tid;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_total = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #2 clk = ~clk;

    fgmt_thread_select dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_start (miss_start),
        .miss_done  (miss_done),
        .delay_issue(delay_issue),
        .sel_tid    (sel_tid),
        .sel_valid  (sel_valid)
    );

    task automatic push_exp(input logic ev, input logic [1:0] et, input string tag);
        exp_t e;
        e.v   = ev;
        e.tid = et;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Driver: inputs for one cycle plus the selection expected in that cycle
    task automatic cyc(input logic [3:0] ms, input logic [3:0] md, input logic [3:0] lb,
                       input logic ev, input logic [1:0] et, input string tag);
        @(negedge clk);
        miss_start  = ms;
        miss_done   = md;
        delay_issue = lb;
        push_exp(ev, et, tag);
    endtask

    // Monitor / scoreboard
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_total++;
                if (sel_valid !== e.v || sel_tid !== e.tid) begin
                    n_fail++;
                    $display("FAIL %s: got valid=%0b tid=%0d, expected valid=%0b tid=%0d",
                             e.tag, sel_valid, sel_tid, e.v, e.tid);
                end
            end
        end
    end

    initial begin
        #(40000 * 4);
        if (!done) begin
            n_total++;
            n_fail++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        push_exp(1'b1, 2'd0, "R1 in reset");
        @(negedge clk);
        rst_n = 1'b1;
        push_exp(1'b1, 2'd0, "R1 first after reset");
        // R1 / R2: free rotation
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R1 R2 rotate");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2, "R1 R2 rotate");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, "R1 R2 rotate");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0, "R1 R2 wrap");
        // R5: load shadow on thread 1
        cyc(4'b0000, 4'b0000, 4'b0010, 1'b1, 2'd1, "R5 issue");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2, "R5 shadow 1");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, "R5 shadow 2");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0, "R5 shadow 3");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R5 back");
        // R4 / R3: miss on thread 2
        cyc(4'b0100, 4'b0000, 4'b0000, 1'b1, 2'd2, "R4 miss begin");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, "R4 R3 skip");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0, "R4 R3 skip");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R4 R3 skip");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, "R3 skip stalled 2");
        cyc(4'b0000, 4'b0100, 4'b0000, 1'b1, 2'd0, "R4 miss done");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R4 after done");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2, "R4 thread back");
        // R8: miss_done on ready thread 3
        cyc(4'b0000, 4'b1000, 4'b0000, 1'b1, 2'd3, "R8 stray done");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0, "R8 no effect");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R8 no effect");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2, "R8 no effect");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, "R8 thread 3 kept");
        // R6: reload in shadow on thread 0
        cyc(4'b0000, 4'b0000, 4'b0001, 1'b1, 2'd0, "R6 issue");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R6 shadow");
        cyc(4'b0000, 4'b0000, 4'b0001, 1'b1, 2'd2, "R6 reload");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, "R6 shadow");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R6 still out");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2, "R6 still out");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, "R6 rotate");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0, "R6 back");
        // R7 / R9: miss during shadow, issue during miss, thread 1
        cyc(4'b0000, 4'b0000, 4'b0010, 1'b1, 2'd1, "R7 issue");
        cyc(4'b0010, 4'b0000, 4'b0000, 1'b1, 2'd2, "R7 miss in shadow");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, "R7 out");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0, "R7 out");
        cyc(4'b0000, 4'b0000, 4'b0010, 1'b1, 2'd2, "R7 stays past shadow");
        cyc(4'b0000, 4'b0010, 4'b0000, 1'b1, 2'd3, "R9 miss done");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd0, "R9 rotate");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R9 issue ignored");
        // R11 / R10: single ready thread, then none
        cyc(4'b1101, 4'b0000, 4'b0000, 1'b1, 2'd2, "R11 park three");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R11 single");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R11 single repeat");
        cyc(4'b0000, 4'b0000, 4'b0010, 1'b1, 2'd1, "R11 single issue");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, "R10 bubble");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, "R10 bubble");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b0, 2'd0, "R10 bubble");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd1, "R10 resume");
        cyc(4'b0000, 4'b1111, 4'b0000, 1'b1, 2'd1, "R10 R8 release");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd2, "R10 last kept");
        cyc(4'b0000, 4'b0000, 4'b0000, 1'b1, 2'd3, "R3 rotate");
        @(negedge clk);
        miss_start  = '0;
        miss_done   = '0;
        delay_issue = '0;
        repeat (3) @(negedge clk);
        #2;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end

endmodule